// File: doc/BRIEF.md
# Frame Elastic Buffer with Whole-Frame Slip

This block sits between a receive path, whose octet timing follows the incoming line, and the local system path. Received octets are written into a small dual-port store, addressed by the receive time slot. System-side octets are read back, addressed by the system time slot. Both sides run on one clock and advance through per-octet enables; any clock-domain crossing is done before the block's inputs.

The store holds one and a half frames. At the start of every system-side frame the controller measures how far the writer is ahead of the frame about to be read. When the two sides are about to collide, it re-reads the previous frame or skips one frame. The frame structure is therefore never broken. A single-frame mode shrinks the ring to one frame, which keeps the delay below one frame. In that mode slips happen by themselves as the writer's phase wraps, and they are reported when that happens.

Each slip gives a one-cycle indication that says whether a frame was dropped or repeated. Writes are ignored while the receive side reports loss of frame alignment.

Top module: `frame_elastic_buffer`

## Requirements
- R1: With `buf_inhibit`=0 the store is a ring of 48 octets. Each received frame takes the next 32 ring positions, and its slot k sits k positions after the frame's start.
- R2: Every system frame of 32 octets comes from one single received frame. Relative to the previous system frame, the received frame number advances by 1 with no slip, by 2 after a drop, and by 0 after a repeat.
- R3: At a slot-0 read in full mode, let d be the number of ring positions from the next frame start to the write position, modulo 48. If d<4 the previous frame is re-read (repeat). If d>44 one frame is skipped (drop). Otherwise the next frame is read.
- R4: With `buf_inhibit`=1 the ring is 32 octets. After 40 octets have been written, a slot-0 read returns the second received frame, and a read of slot 8 returns the first.
- R5: After a slip, the distance lies far from the opposite threshold. Jitter of one octet around a threshold therefore never produces both drops and repeats.
- R6: Slow wander that keeps d between 4 and 44 causes no slip.
- R7: `slip_pulse` is high for exactly the cycle after a slot-0 read whose decision was a slip. `slip_is_drop` is 1 for a drop and 0 for a repeat. At every other time `slip_pulse` is 0.
- R8: `sys_octet` shows the octet addressed by a read one cycle after `sys_rd_en`.
- R9: While `rx_in_sync`=0, write enables change neither the store nor the write position.
- R10: Reset clears `slip_pulse` and `sys_octet`. The first system frame after reset starts at ring position 0, and a single-frame run reports no slip on its first frame.
- R11: In single-frame mode, a slip is reported when d jumps by more than half a frame between two consecutive frame starts. A downward jump is a drop (the writer gained a frame); an upward jump is a repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_inhibit | input | 1 | 1 = single-frame ring, 0 = 1.5-frame ring; held constant outside reset |
| rx_in_sync | input | 1 | Receive side frame-aligned |
| rx_wr_en | input | 1 | A received octet is present this cycle |
| rx_slot | input | 5 | Receive time slot of the octet |
| rx_octet | input | 8 | Received octet |
| sys_rd_en | input | 1 | Read one octet this cycle |
| sys_slot | input | 5 | System time slot to read |
| sys_octet | output | 8 | Read octet, one cycle after the read |
| slip_pulse | output | 1 | A frame slip was decided at the last slot-0 read |
| slip_is_drop | output | 1 | Kind of that slip: 1 drop, 0 repeat |

## Verification
All results are registered once, so data and slip flags for a read driven at one falling edge are due after the next rising edge. The bench drives inputs on falling edges and samples one falling edge later, before it drives again. Directed vectors fill the ring to a chosen distance and then issue a single slot-0 read; they check the slip flags and the frame tag in that sampled cycle. The streaming runs track the frame tag across frames and count slips. This checks frame integrity and the slip kinds, not the exact cycle of each wander-driven slip.

// File: rtl/febuf_pkg.sv
package febuf_pkg;

    parameter int SLOTS   = 32;
    parameter int OCTET_W = 8;
    parameter int GUARD   = 4;

    localparam int DEPTH = SLOTS + SLOTS / 2;
    localparam int AW    = $clog2(DEPTH);
    localparam int SW    = $clog2(SLOTS);

    typedef logic [AW-1:0]      addr_t;
    typedef logic [SW-1:0]      slot_t;
    typedef logic [OCTET_W-1:0] octet_t;

    typedef enum logic [1:0] {
        SLIP_NONE   = 2'd0,
        SLIP_REPEAT = 2'd1,
        SLIP_DROP   = 2'd2
    } slip_e;

    typedef struct packed {
        logic   en;
        addr_t  addr;
        octet_t data;
    } wr_req_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
    } rd_req_t;

    function automatic int ring_size(logic one_frame);
        return one_frame ? SLOTS : DEPTH;
    endfunction

    function automatic addr_t ring_add(addr_t a, int b, logic one_frame);
        return addr_t'((int'(a) + b) % ring_size(one_frame));
    endfunction

    function automatic addr_t ring_dist(addr_t from, addr_t to, logic one_frame);
        int m;
        m = ring_size(one_frame);
        return addr_t'((int'(to) - int'(from) + m) % m);
    endfunction

    // Full ring: hysteresis thresholds on the lead of the writer.
    function automatic slip_e judge_full(addr_t d);
        if (int'(d) < GUARD)              return SLIP_REPEAT;
        else if (int'(d) > DEPTH - GUARD) return SLIP_DROP;
        else                              return SLIP_NONE;
    endfunction

    // Single-frame ring: a jump of the lead by over half a frame is a wrap.
    function automatic slip_e judge_wrap(addr_t prev, addr_t now);
        int diff;
        diff = int'(now) - int'(prev);
        if (diff < -(SLOTS / 2))    return SLIP_DROP;
        else if (diff > SLOTS / 2)  return SLIP_REPEAT;
        else                        return SLIP_NONE;
    endfunction

endpackage

// File: rtl/febuf_wr_ctrl.sv
module febuf_wr_ctrl
    import febuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    one_frame,
    input  logic    in_sync,
    input  logic    wr_en,
    input  slot_t   wr_slot,
    input  octet_t  wr_data,
    output wr_req_t wr_req,
    output addr_t   wr_pos
);

    addr_t frame_start;
    addr_t slot_addr;
    logic  accept;

    assign accept    = wr_en && in_sync;
    assign slot_addr = ring_add(frame_start, int'(wr_slot), one_frame);

    always_comb begin
        wr_req.en   = accept;
        wr_req.addr = slot_addr;
        wr_req.data = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start <= '0;
            wr_pos      <= '0;
        end else if (accept) begin
            wr_pos <= ring_add(slot_addr, 1, one_frame);
            if (wr_slot == slot_t'(SLOTS - 1))
                frame_start <= ring_add(frame_start, SLOTS, one_frame);
        end
    end

    assert_wpos_in_ring_R1: assert property (@(posedge clk) disable iff (rst)
        int'(wr_pos) < ring_size(one_frame));

    assert_unsynced_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_sync) |=> $stable(wr_pos));

endmodule

// File: rtl/febuf_rd_ctrl.sv
module febuf_rd_ctrl
    import febuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    one_frame,
    input  logic    rd_en,
    input  slot_t   rd_slot,
    input  addr_t   wr_pos,
    output rd_req_t rd_req,
    output logic    slip_o,
    output logic    slip_drop_o
);

    addr_t rd_base;
    addr_t lead_prev;
    logic  lead_prev_ok;

    addr_t next_base;
    addr_t chosen;
    addr_t lead;
    addr_t frame_base;
    slip_e verdict;
    logic  head;
    logic  decide;

    assign head   = (rd_slot == '0);
    assign decide = rd_en && head;

    always_comb begin
        next_base = ring_add(rd_base, SLOTS, one_frame);
        lead      = ring_dist(next_base, wr_pos, one_frame);
        verdict   = SLIP_NONE;
        chosen    = next_base;
        if (!one_frame) begin
            verdict = judge_full(lead);
            if (verdict == SLIP_REPEAT)
                chosen = rd_base;
            else if (verdict == SLIP_DROP)
                chosen = ring_add(next_base, SLOTS, 1'b0);
        end else if (lead_prev_ok) begin
            verdict = judge_wrap(lead_prev, lead);
        end
        frame_base  = head ? chosen : rd_base;
        rd_req.en   = rd_en;
        rd_req.addr = ring_add(frame_base, int'(rd_slot), one_frame);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_base      <= one_frame ? '0 : addr_t'(DEPTH - SLOTS);
            lead_prev    <= '0;
            lead_prev_ok <= 1'b0;
            slip_o       <= 1'b0;
            slip_drop_o  <= 1'b0;
        end else begin
            slip_o      <= 1'b0;
            slip_drop_o <= 1'b0;
            if (decide) begin
                rd_base      <= chosen;
                lead_prev    <= lead;
                lead_prev_ok <= 1'b1;
                slip_o       <= (verdict != SLIP_NONE);
                slip_drop_o  <= (verdict == SLIP_DROP);
            end
        end
    end

    assert_slip_after_head_R7: assert property (@(posedge clk) disable iff (rst)
        slip_o |-> $past(decide));

    assert_drop_flag_qualified_R7: assert property (@(posedge clk) disable iff (rst)
        slip_drop_o |-> slip_o);

    assert_single_frame_addr_R4: assert property (@(posedge clk) disable iff (rst)
        one_frame |-> (int'(rd_req.addr) < SLOTS));

    assert_base_in_ring_R1: assert property (@(posedge clk) disable iff (rst)
        int'(rd_base) < ring_size(one_frame));

endmodule

// File: rtl/febuf_store.sv
module febuf_store
    import febuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr_req,
    input  rd_req_t rd_req,
    output octet_t  rd_data
);

    octet_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_req.en)
            mem[wr_req.addr] <= wr_req.data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_req.en)
            rd_data <= mem[rd_req.addr];
    end

    assert_addr_bounds_R1: assert property (@(posedge clk) disable iff (rst)
        (!wr_req.en || int'(wr_req.addr) < DEPTH) && (!rd_req.en || int'(rd_req.addr) < DEPTH));

endmodule

// File: rtl/frame_elastic_buffer.sv
module frame_elastic_buffer
    import febuf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  buf_inhibit,
    input  logic                  rx_in_sync,
    input  logic                  rx_wr_en,
    input  logic [SW-1:0]         rx_slot,
    input  logic [OCTET_W-1:0]    rx_octet,
    input  logic                  sys_rd_en,
    input  logic [SW-1:0]         sys_slot,
    output logic [OCTET_W-1:0]    sys_octet,
    output logic                  slip_pulse,
    output logic                  slip_is_drop
);

    wr_req_t wr_req;
    rd_req_t rd_req;
    addr_t   wr_pos;

    febuf_wr_ctrl u_wr (
        .clk       (clk),
        .rst       (rst),
        .one_frame (buf_inhibit),
        .in_sync   (rx_in_sync),
        .wr_en     (rx_wr_en),
        .wr_slot   (rx_slot),
        .wr_data   (rx_octet),
        .wr_req    (wr_req),
        .wr_pos    (wr_pos)
    );

    febuf_rd_ctrl u_rd (
        .clk         (clk),
        .rst         (rst),
        .one_frame   (buf_inhibit),
        .rd_en       (sys_rd_en),
        .rd_slot     (sys_slot),
        .wr_pos      (wr_pos),
        .rd_req      (rd_req),
        .slip_o      (slip_pulse),
        .slip_drop_o (slip_is_drop)
    );

    febuf_store u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .rd_req  (rd_req),
        .rd_data (sys_octet)
    );

    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(rst) |-> (!slip_pulse && sys_octet == '0));

endmodule

// File: tb/frame_elastic_buffer_test.sv
module frame_elastic_buffer_test;
    import febuf_pkg::*;

    localparam int PERIOD   = 10;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         buf_inhibit = 1'b0;
    logic         rx_in_sync = 1'b0;
    logic         rx_wr_en = 1'b0;
    logic [4:0]   rx_slot = '0;
    logic [7:0]   rx_octet = '0;
    logic         sys_rd_en = 1'b0;
    logic [4:0]   sys_slot = '0;
    logic [7:0]   sys_octet;
    logic         slip_pulse;
    logic         slip_is_drop;

    int vectors = 0;
    int errors  = 0;

    always #(PERIOD/2) clk = ~clk;

    frame_elastic_buffer uut (
        .clk(clk), .rst(rst), .buf_inhibit(buf_inhibit), .rx_in_sync(rx_in_sync),
        .rx_wr_en(rx_wr_en), .rx_slot(rx_slot), .rx_octet(rx_octet),
        .sys_rd_en(sys_rd_en), .sys_slot(sys_slot), .sys_octet(sys_octet),
        .slip_pulse(slip_pulse), .slip_is_drop(slip_is_drop)
    );

    // slip codes: 0 none, 1 repeat, 2 drop
    typedef struct packed {
        logic inh;
        int   pre;
        int   slip;
        logic chk;
        int   tag;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 40, 0, 1'b1, 0},   // R3 mid range
        '{1'b0,  3, 1, 1'b0, 0},   // R3 repeat below guard
        '{1'b0,  4, 0, 1'b1, 0},   // R3 lower edge
        '{1'b0, 44, 0, 1'b1, 0},   // R3 upper edge
        '{1'b0, 45, 2, 1'b1, 1},   // R3 drop, R1 frame 1 at ring 32
        '{1'b1, 40, 0, 1'b1, 1},   // R4 one-frame ring overwritten
        '{1'b1, 20, 0, 1'b1, 0}    // R10 first single-frame decision
    };

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        vectors++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic do_reset(input logic inh);
        @(negedge clk);
        rst = 1'b1; buf_inhibit = inh;
        rx_wr_en = 1'b0; sys_rd_en = 1'b0; rx_in_sync = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_raw(input int slot, input int data, input logic sync);
        rx_wr_en = 1'b1; rx_in_sync = sync;
        rx_slot = 5'(slot); rx_octet = 8'(data);
        @(negedge clk);
        rx_wr_en = 1'b0; rx_in_sync = 1'b1;
    endtask

    task automatic write_idx(input int idx);
        write_raw(idx % 32, ((idx / 32) % 8) * 32 + idx % 32, 1'b1);
    endtask

    task automatic read_slot(input int s);
        sys_rd_en = 1'b1; sys_slot = 5'(s);
        @(negedge clk);
        sys_rd_en = 1'b0;
    endtask

    task automatic stream(input string tag, input logic inh, input int pre, input int wp,
                          input int rp, input int frames, input logic chk_data,
                          input int dlo, input int dhi, input int rlo, input int rhi);
        int wi, ri, cyc, pslot, cur_tag, prev_tag, ndrop, nrep, exp_tag;
        logic pend;
        do_reset(inh);
        for (int i = 0; i < pre; i++) write_idx(i);
        wi = pre; ri = 0; cyc = 0; pend = 1'b0; pslot = 0;
        cur_tag = 0; prev_tag = 7; ndrop = 0; nrep = 0;
        while (ri < frames * 32 || pend) begin
            if (pend) begin
                if (pslot == 0) begin
                    cur_tag = int'(sys_octet[7:5]);
                    if (slip_pulse && slip_is_drop) ndrop++;
                    else if (slip_pulse) nrep++;
                    exp_tag = slip_pulse ? (slip_is_drop ? prev_tag + 2 : prev_tag) : prev_tag + 1;
                    if (chk_data) check({tag, " R2 frame tag"}, cur_tag, exp_tag % 8);
                    prev_tag = cur_tag;
                end else begin
                    check({tag, " R7 no pulse mid-frame"}, int'(slip_pulse), 0);
                end
                if (chk_data) // R8 data one cycle after the read
                    check({tag, " R2 R8 octet"}, int'(sys_octet), cur_tag * 32 + pslot);
            end
            cyc++;
            if (wp != 0 && cyc % wp == 0) begin
                rx_wr_en = 1'b0;
            end else begin
                rx_wr_en = 1'b1; rx_slot = 5'(wi % 32);
                rx_octet = 8'(((wi / 32) % 8) * 32 + wi % 32);
                wi++;
            end
            if (ri < frames * 32 && !(rp != 0 && cyc % rp == rp / 2)) begin
                sys_rd_en = 1'b1; sys_slot = 5'(ri % 32);
                pend = 1'b1; pslot = ri % 32; ri++;
            end else begin
                sys_rd_en = 1'b0; pend = 1'b0;
            end
            @(negedge clk);
        end
        rx_wr_en = 1'b0; sys_rd_en = 1'b0;
        check_range({tag, " drops"}, ndrop, dlo, dhi);
        check_range({tag, " repeats"}, nrep, rlo, rhi);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        // R10 reset state
        do_reset(1'b0);
        check("R10 slip after reset", int'(slip_pulse), 0);
        check("R10 octet after reset", int'(sys_octet), 0);

        // Vector table: fill to a distance, then one slot-0 read
        foreach (VECS[v]) begin
            do_reset(VECS[v].inh);
            for (int i = 0; i < VECS[v].pre; i++) write_idx(i);
            read_slot(0);
            check("R3 R7 slip pulse", int'(slip_pulse), int'(VECS[v].slip != 0));
            check("R3 R7 drop flag", int'(slip_is_drop), int'(VECS[v].slip == 2));
            if (VECS[v].chk) begin
                check("R1 R4 slot0 tag", int'(sys_octet[7:5]), VECS[v].tag);
                check("R1 R4 slot0 field", int'(sys_octet[4:0]), 0);
            end
        end

        // R4 slot 8 in single-frame ring still holds frame 0
        do_reset(1'b1);
        for (int i = 0; i < 40; i++) write_idx(i);
        read_slot(0);
        read_slot(8);
        check("R4 slot8 old frame", int'(sys_octet), 8);

        // R9 writes ignored while out of sync
        do_reset(1'b0);
        for (int i = 0; i < 32; i++) write_idx(i);
        for (int i = 0; i < 32; i++) write_raw(i, 5 * 32 + i, 1'b0);
        for (int i = 32; i < 40; i++) write_idx(i);
        read_slot(0);
        check("R9 store untouched", int'(sys_octet), 0);
        check("R9 no slip", int'(slip_pulse), 0);
        read_slot(0);
        check("R9 write position unmoved", int'(sys_octet), 32);

        // Streaming runs
        stream("R6 slow wander",        1'b0, 16, 64,  0, 12, 1'b1, 0, 0, 0, 0);
        stream("R3 writer fast drop",   1'b0, 16,  0, 32, 40, 1'b1, 1, 2, 0, 0);
        stream("R3 writer slow repeat", 1'b0, 16, 32,  0, 20, 1'b1, 0, 0, 1, 2);
        stream("R5 jitter at edge",     1'b0, 44, 64, 64, 16, 1'b1, 0, 1, 0, 0);
        stream("R11 single drop",       1'b1, 16,  0, 32, 24, 1'b0, 1, 2, 0, 0);
        stream("R11 single repeat",     1'b1, 16, 32,  0, 24, 1'b0, 0, 0, 1, 2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule